// File: doc/BRIEF.md
# Paged Ethernet Controller Register File with Interrupt Logic

This block is the byte-wide register file of a legacy Ethernet controller. A host reaches it through a 4-bit offset and single-cycle read and write strobes. Offset 0 is the command register on every page. The two top bits of the command register pick one of four pages, and that page gives meaning to offsets 1 to 15. An offset can name one register when written and a different register when read. For example, the ring start and ring stop bytes are written on page 0 and read back on page 2, while a page 0 read at those offsets returns the local DMA address, which the receive datapath supplies.

The block holds the interrupt status and mask registers and drives one level-sensitive interrupt line. The receive and transmit datapaths raise status bits through set strobes. Software clears those bits by writing ones. The top status bit reports that the controller is held in reset. It never raises the interrupt and is cleared by a command write that releases the stop bit. Ring pointers, the transmit page and count, and the remote DMA address and count are also held here and driven out to the datapaths. An access to an offset that has no register on the current page returns zero, changes nothing and pulses an error flag.

Top module: `nic_regfile_top`

## Requirements
- R1: After reset the command register reads 0x22, the mask register reads 0x00, the status register reads 0x80 (reset-status bit 7 set, bits 6:0 clear), all eight multicast mask bytes read 0xFF and every other stored register reads 0x00.
- R2: Offset 0 is the command register on every page and reads back the last value written to it. Command bits 7:6 select the page used for offsets 1 to 15, and bit 0 is the stop bit, which is driven out on `stop_o`.
- R3: `irq_o` is high exactly when the status register AND the mask register is nonzero in bits 6:0. Status bit 7 never raises it.
- R4: A write to page 0 offset 7 clears each status bit 6:0 whose data bit is one and leaves the other status bits unchanged. Bit 7 is never changed by this write.
- R5: A command write with data bit 0 clear clears status bit 7. A command write with bit 0 set leaves it unchanged.
- R6: A set strobe `isr_set_i[k]` sets status bit k on the next edge. If a clear write hits the same bit in the same cycle, the strobe wins.
- R7: Page 1 reads and writes the six station address bytes at offsets 1 to 6, the current ring page at offset 7 and the eight multicast mask bytes at offsets 8 to 15.
- R8: On page 0, writes to offsets 1 and 2 load ring start and ring stop, while reads at those offsets return `ldma_addr_i` low and high bytes. On page 2, reads at offsets 1 and 2 return ring start and ring stop.
- R9: The other page 0 writes go as follows: boundary (3), transmit page (4), transmit count low/high (5/6), remote address low/high (8/9), remote count low/high (10/11), receive config (12), transmit config (13), data config (14) and mask (15). Page 0 reads return boundary (3), status (7) and remote address low/high (8/9). Page 2 reads return transmit page (4), receive config (12), transmit config (13), data config (14) and mask (15).
- R10: The undefined locations are the page 0 reads at offsets 4, 5, 6 and 10 to 15, the page 2 reads at offsets 3 and 5 to 11, every page 2 write, and every page 3 access at offsets 1 to 15. A read there returns 0x00, a write there changes nothing, and either one raises `err_o` for exactly one cycle after the access. A defined access leaves `err_o` low.
- R11: The ring, transmit and remote DMA outputs show the value written to their registers from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_rd_i | input | 1 | Read strobe; `reg_rdata_o` is valid in the same cycle |
| reg_wr_i | input | 1 | Write strobe, committed on the rising edge |
| reg_addr_i | input | 4 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the current page and offset |
| err_o | output | 1 | One-cycle pulse after an undefined access |
| isr_set_i | input | 7 | Status set strobes from the datapaths |
| ldma_addr_i | input | 16 | Local DMA address from the receive datapath |
| irq_o | output | 1 | Level interrupt |
| stop_o | output | 1 | Command stop bit |
| ring_start_o | output | 8 | Ring start page |
| ring_stop_o | output | 8 | Ring stop page |
| ring_bound_o | output | 8 | Ring boundary page |
| ring_curr_o | output | 8 | Current ring page |
| tx_page_o | output | 8 | Transmit start page |
| tx_count_o | output | 16 | Transmit byte count |
| rdma_addr_o | output | 16 | Remote DMA address |
| rdma_count_o | output | 16 | Remote DMA byte count |

## Verification
The bench builds the block with its default sizes: six station bytes, eight multicast bytes, seven interrupt-capable status bits and a 4-bit offset. These sizes are small enough to sweep all 64 page and offset pairs for reads and writes, both straight after reset and after a full write pass, against a model of the read and write maps. The same sizes allow all 256 mask values to be crossed with a set-then-clear of each status bit. That sweep exposes any leak of bit 7 into the interrupt and any slip in the write-one-to-clear path.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int DW       = 8;
  localparam int OFF_W    = 4;
  localparam int STA_N    = 6;
  localparam int MC_N     = 8;
  localparam int IRQ_BITS = 7;
  localparam int STOP_BIT = 0;
  localparam int PG_LSB   = 6;

  localparam logic [DW-1:0] CMD_RST = 8'h22;
  localparam logic [DW-1:0] ISR_RST = 8'h80;
  localparam logic [DW-1:0] MC_RST  = 8'hFF;

  typedef enum logic [1:0] {
    PG_RUN  = 2'd0,
    PG_ADDR = 2'd1,
    PG_MIRR = 2'd2,
    PG_RSVD = 2'd3
  } page_e;

  localparam logic [OFF_W-1:0] O_CMD   = 4'd0;
  localparam logic [OFF_W-1:0] O_START = 4'd1;
  localparam logic [OFF_W-1:0] O_STOP  = 4'd2;
  localparam logic [OFF_W-1:0] O_BOUND = 4'd3;
  localparam logic [OFF_W-1:0] O_TPG   = 4'd4;
  localparam logic [OFF_W-1:0] O_TCL   = 4'd5;
  localparam logic [OFF_W-1:0] O_TCH   = 4'd6;
  localparam logic [OFF_W-1:0] O_ISR   = 4'd7;
  localparam logic [OFF_W-1:0] O_RAL   = 4'd8;
  localparam logic [OFF_W-1:0] O_RAH   = 4'd9;
  localparam logic [OFF_W-1:0] O_RCL   = 4'd10;
  localparam logic [OFF_W-1:0] O_RCH   = 4'd11;
  localparam logic [OFF_W-1:0] O_RXC   = 4'd12;
  localparam logic [OFF_W-1:0] O_TXC   = 4'd13;
  localparam logic [OFF_W-1:0] O_DC    = 4'd14;
  localparam logic [OFF_W-1:0] O_MASK  = 4'd15;
  localparam logic [OFF_W-1:0] O_CURR  = 4'd7;
  localparam int               O_STA0  = 1;
  localparam int               O_MC0   = 8;
endpackage

// File: rtl/nic_cmd_status.sv
module nic_cmd_status
  import nic_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr_i,
  input  logic                isr_wr_i,
  input  logic                imr_wr_i,
  input  logic [DW-1:0]       wdata_i,
  input  logic [IRQ_BITS-1:0] set_i,
  output logic [DW-1:0]       cmd_q,
  output logic [DW-1:0]       isr_q,
  output logic [DW-1:0]       imr_q,
  output logic                irq_o
);
  logic [DW-1:0] isr_d;

  always_comb begin
    isr_d = isr_q;
    if (isr_wr_i)
      isr_d[IRQ_BITS-1:0] = isr_q[IRQ_BITS-1:0] & ~wdata_i[IRQ_BITS-1:0];
    if (cmd_wr_i && !wdata_i[STOP_BIT])
      isr_d[DW-1] = 1'b0;
    // datapath strobes override a same-cycle clear
    isr_d[IRQ_BITS-1:0] = isr_d[IRQ_BITS-1:0] | set_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST;
      isr_q <= ISR_RST;
      imr_q <= '0;
    end else begin
      isr_q <= isr_d;
      if (cmd_wr_i) cmd_q <= wdata_i;
      if (imr_wr_i) imr_q <= wdata_i;
    end
  end

  assign irq_o = |(isr_q[IRQ_BITS-1:0] & imr_q[IRQ_BITS-1:0]);
endmodule

// File: rtl/nic_page_store.sv
module nic_page_store
  import nic_regs_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_i,
  input  logic [1:0]                 page_i,
  input  logic [OFF_W-1:0]           off_i,
  input  logic [DW-1:0]              wdata_i,
  output logic [DW-1:0]              start_q,
  output logic [DW-1:0]              stop_q,
  output logic [DW-1:0]              bound_q,
  output logic [DW-1:0]              tpg_q,
  output logic [2*DW-1:0]            tcnt_q,
  output logic [2*DW-1:0]            raddr_q,
  output logic [2*DW-1:0]            rcnt_q,
  output logic [DW-1:0]              rxc_q,
  output logic [DW-1:0]              txc_q,
  output logic [DW-1:0]              dc_q,
  output logic [DW-1:0]              curr_q,
  output logic [STA_N-1:0][DW-1:0]   sta_q,
  output logic [MC_N-1:0][DW-1:0]    mc_q
);
  logic wr_run, wr_addr;
  assign wr_run  = wr_i && (page_i == PG_RUN);
  assign wr_addr = wr_i && (page_i == PG_ADDR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= '0; stop_q <= '0; bound_q <= '0; tpg_q <= '0;
      tcnt_q  <= '0; raddr_q <= '0; rcnt_q <= '0;
      rxc_q   <= '0; txc_q <= '0; dc_q <= '0;
    end else if (wr_run) begin
      unique case (off_i)
        O_START: start_q            <= wdata_i;
        O_STOP:  stop_q             <= wdata_i;
        O_BOUND: bound_q            <= wdata_i;
        O_TPG:   tpg_q              <= wdata_i;
        O_TCL:   tcnt_q[DW-1:0]     <= wdata_i;
        O_TCH:   tcnt_q[2*DW-1:DW]  <= wdata_i;
        O_RAL:   raddr_q[DW-1:0]    <= wdata_i;
        O_RAH:   raddr_q[2*DW-1:DW] <= wdata_i;
        O_RCL:   rcnt_q[DW-1:0]     <= wdata_i;
        O_RCH:   rcnt_q[2*DW-1:DW]  <= wdata_i;
        O_RXC:   rxc_q              <= wdata_i;
        O_TXC:   txc_q              <= wdata_i;
        O_DC:    dc_q               <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                          curr_q <= '0;
    else if (wr_addr && off_i == O_CURR) curr_q <= wdata_i;
  end

  for (genvar s = 0; s < STA_N; s++) begin : g_sta
    localparam logic [OFF_W-1:0] SEL = OFF_W'(O_STA0 + s);
    always_ff @(posedge clk) begin
      if (!rst_n)                      sta_q[s] <= '0;
      else if (wr_addr && off_i == SEL) sta_q[s] <= wdata_i;
    end
  end

  for (genvar m = 0; m < MC_N; m++) begin : g_mc
    localparam logic [OFF_W-1:0] SEL = OFF_W'(O_MC0 + m);
    always_ff @(posedge clk) begin
      if (!rst_n)                      mc_q[m] <= MC_RST;
      else if (wr_addr && off_i == SEL) mc_q[m] <= wdata_i;
    end
  end
endmodule

// File: rtl/nic_read_mux.sv
module nic_read_mux
  import nic_regs_pkg::*;
(
  input  logic [1:0]               page_i,
  input  logic [OFF_W-1:0]         off_i,
  input  logic [DW-1:0]            cmd_i,
  input  logic [DW-1:0]            isr_i,
  input  logic [DW-1:0]            imr_i,
  input  logic [2*DW-1:0]          ldma_i,
  input  logic [DW-1:0]            start_i,
  input  logic [DW-1:0]            stop_i,
  input  logic [DW-1:0]            bound_i,
  input  logic [DW-1:0]            tpg_i,
  input  logic [2*DW-1:0]          raddr_i,
  input  logic [DW-1:0]            rxc_i,
  input  logic [DW-1:0]            txc_i,
  input  logic [DW-1:0]            dc_i,
  input  logic [DW-1:0]            curr_i,
  input  logic [STA_N-1:0][DW-1:0] sta_i,
  input  logic [MC_N-1:0][DW-1:0]  mc_i,
  output logic [DW-1:0]            rdata_o,
  output logic                     hit_o
);
  page_e pg;
  assign pg = page_e'(page_i);

  always_comb begin
    rdata_o = '0;
    hit_o   = 1'b1;
    if (off_i == O_CMD) begin
      rdata_o = cmd_i;
    end else begin
      unique case (pg)
        PG_RUN: begin
          unique case (off_i)
            O_START: rdata_o = ldma_i[DW-1:0];
            O_STOP:  rdata_o = ldma_i[2*DW-1:DW];
            O_BOUND: rdata_o = bound_i;
            O_ISR:   rdata_o = isr_i;
            O_RAL:   rdata_o = raddr_i[DW-1:0];
            O_RAH:   rdata_o = raddr_i[2*DW-1:DW];
            default: hit_o   = 1'b0;
          endcase
        end
        PG_ADDR: begin
          if (off_i == O_CURR)
            rdata_o = curr_i;
          else if (int'(off_i) >= O_MC0)
            rdata_o = mc_i[int'(off_i) - O_MC0];
          else
            rdata_o = sta_i[int'(off_i) - O_STA0];
        end
        PG_MIRR: begin
          unique case (off_i)
            O_START: rdata_o = start_i;
            O_STOP:  rdata_o = stop_i;
            O_TPG:   rdata_o = tpg_i;
            O_RXC:   rdata_o = rxc_i;
            O_TXC:   rdata_o = txc_i;
            O_DC:    rdata_o = dc_i;
            O_MASK:  rdata_o = imr_i;
            default: hit_o   = 1'b0;
          endcase
        end
        default: hit_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/nic_regfile_top.sv
module nic_regfile_top
  import nic_regs_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_rd_i,
  input  logic                reg_wr_i,
  input  logic [OFF_W-1:0]    reg_addr_i,
  input  logic [DW-1:0]       reg_wdata_i,
  output logic [DW-1:0]       reg_rdata_o,
  output logic                err_o,
  input  logic [IRQ_BITS-1:0] isr_set_i,
  input  logic [2*DW-1:0]     ldma_addr_i,
  output logic                irq_o,
  output logic                stop_o,
  output logic [DW-1:0]       ring_start_o,
  output logic [DW-1:0]       ring_stop_o,
  output logic [DW-1:0]       ring_bound_o,
  output logic [DW-1:0]       ring_curr_o,
  output logic [DW-1:0]       tx_page_o,
  output logic [2*DW-1:0]     tx_count_o,
  output logic [2*DW-1:0]     rdma_addr_o,
  output logic [2*DW-1:0]     rdma_count_o
);
  logic [DW-1:0] cmd_q, isr_q, imr_q;
  logic [1:0]    page;
  logic          is_cmd, wr_ok, rd_hit, err_q;
  logic          cmd_wr, isr_wr, imr_wr;

  logic [DW-1:0]            rxc, txc, dc;
  logic [STA_N-1:0][DW-1:0] sta;
  logic [MC_N-1:0][DW-1:0]  mc;

  assign page   = cmd_q[PG_LSB +: 2];
  assign is_cmd = (reg_addr_i == O_CMD);
  assign wr_ok  = is_cmd || (page == PG_RUN) || (page == PG_ADDR);
  assign cmd_wr = reg_wr_i && is_cmd;
  assign isr_wr = reg_wr_i && (page == PG_RUN) && (reg_addr_i == O_ISR);
  assign imr_wr = reg_wr_i && (page == PG_RUN) && (reg_addr_i == O_MASK);

  nic_cmd_status cs_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr_i (cmd_wr),
    .isr_wr_i (isr_wr),
    .imr_wr_i (imr_wr),
    .wdata_i  (reg_wdata_i),
    .set_i    (isr_set_i),
    .cmd_q    (cmd_q),
    .isr_q    (isr_q),
    .imr_q    (imr_q),
    .irq_o    (irq_o)
  );

  nic_page_store ps_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (reg_wr_i && !is_cmd),
    .page_i  (page),
    .off_i   (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .start_q (ring_start_o),
    .stop_q  (ring_stop_o),
    .bound_q (ring_bound_o),
    .tpg_q   (tx_page_o),
    .tcnt_q  (tx_count_o),
    .raddr_q (rdma_addr_o),
    .rcnt_q  (rdma_count_o),
    .rxc_q   (rxc),
    .txc_q   (txc),
    .dc_q    (dc),
    .curr_q  (ring_curr_o),
    .sta_q   (sta),
    .mc_q    (mc)
  );

  nic_read_mux rm_i (
    .page_i  (page),
    .off_i   (reg_addr_i),
    .cmd_i   (cmd_q),
    .isr_i   (isr_q),
    .imr_i   (imr_q),
    .ldma_i  (ldma_addr_i),
    .start_i (ring_start_o),
    .stop_i  (ring_stop_o),
    .bound_i (ring_bound_o),
    .tpg_i   (tx_page_o),
    .raddr_i (rdma_addr_o),
    .rxc_i   (rxc),
    .txc_i   (txc),
    .dc_i    (dc),
    .curr_i  (ring_curr_o),
    .sta_i   (sta),
    .mc_i    (mc),
    .rdata_o (reg_rdata_o),
    .hit_o   (rd_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (reg_wr_i && !wr_ok) || (reg_rd_i && !rd_hit);
  end

  assign err_o  = err_q;
  assign stop_o = cmd_q[STOP_BIT];
endmodule

// File: rtl/nic_regfile_chk.sv
module nic_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_rd_i,
  input logic       reg_wr_i,
  input logic [3:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [6:0] isr_set_i,
  input logic       irq_o,
  input logic       err_o,
  input logic [7:0] isr_q,
  input logic [7:0] imr_q
);
  // R3
  mask_zero_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (imr_q[6:0] == 7'd0) |-> !irq_o);

  // R3
  set_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (((isr_set_i & imr_q[6:0]) != 7'd0) && !reg_wr_i) |=> irq_o);

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_set_i != 7'd0) |=> ((isr_q[6:0] & $past(isr_set_i)) == $past(isr_set_i)));

  // R5
  rst_bit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 4'd0 && !reg_wdata_i[0]) |=> !isr_q[7]);

  // R10
  err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i || reg_rd_i) |=> !err_o);
endmodule

bind nic_regfile_top nic_regfile_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd_i    (reg_rd_i),
  .reg_wr_i    (reg_wr_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .isr_set_i   (isr_set_i),
  .irq_o       (irq_o),
  .err_o       (err_o),
  .isr_q       (isr_q),
  .imr_q       (imr_q)
);

// File: tb/nic_regfile_top_tb_top.sv
module nic_regfile_top_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_rd_i = 0, reg_wr_i = 0;
  logic [3:0]  reg_addr_i = 0;
  logic [7:0]  reg_wdata_i = 0;
  logic [7:0]  reg_rdata_o;
  logic        err_o, irq_o, stop_o;
  logic [6:0]  isr_set_i = 0;
  logic [15:0] ldma_addr_i = 16'hB3C4;
  logic [7:0]  ring_start_o, ring_stop_o, ring_bound_o, ring_curr_o, tx_page_o;
  logic [15:0] tx_count_o, rdma_addr_o, rdma_count_o;

  int n_chk = 0, n_bad = 0;

  // model of the register maps
  logic [7:0] m_cmd, m_isr, m_imr, m_cur;
  logic [7:0] p0 [16];
  logic [7:0] sta [6];
  logic [7:0] mc [8];

  always #5 clk = ~clk;

  nic_regfile_top dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic void exp_read(input int pg, input int off,
                                   output logic [7:0] d, output bit ok);
    d = 8'h00; ok = 1;
    if (off == 0) d = m_cmd;
    else if (pg == 0) begin
      case (off)
        1: d = ldma_addr_i[7:0];
        2: d = ldma_addr_i[15:8];
        3: d = p0[3];
        7: d = m_isr;
        8: d = p0[8];
        9: d = p0[9];
        default: ok = 0;
      endcase
    end else if (pg == 1) begin
      if (off <= 6) d = sta[off-1];
      else if (off == 7) d = m_cur;
      else d = mc[off-8];
    end else if (pg == 2) begin
      case (off)
        1, 2, 4, 12, 13, 14: d = p0[off];
        15: d = m_imr;
        default: ok = 0;
      endcase
    end else ok = 0;
    if (!ok) d = 8'h00;
  endfunction

  function automatic void model_wr(input int pg, input int off, input logic [7:0] d);
    if (off == 0) begin
      m_cmd = d;
      if (!d[0]) m_isr[7] = 1'b0;
    end else if (pg == 0) begin
      p0[off] = d;
      if (off == 7) m_isr[6:0] = m_isr[6:0] & ~d[6:0];
      if (off == 15) m_imr = d;
    end else if (pg == 1) begin
      if (off <= 6) sta[off-1] = d;
      else if (off == 7) m_cur = d;
      else mc[off-8] = d;
    end
  endfunction

  task automatic wr(input int off, input logic [7:0] d, input bit exp_err, input string tag);
    @(negedge clk);
    reg_wr_i = 1; reg_addr_i = 4'(off); reg_wdata_i = d;
    model_wr(int'(m_cmd[7:6]), off, d);
    @(negedge clk);
    reg_wr_i = 0;
    chk(err_o == exp_err, {tag, " err after write"}, err_o, exp_err);
  endtask

  task automatic rd(input int off, input string tag);
    logic [7:0] e; bit ok;
    exp_read(int'(m_cmd[7:6]), off, e, ok);
    @(negedge clk);
    reg_rd_i = 1; reg_addr_i = 4'(off);
    #1 chk(reg_rdata_o == e, tag, reg_rdata_o, e);
    @(negedge clk);
    reg_rd_i = 0;
    chk(err_o == !ok, {tag, " err after read"}, err_o, !ok);
  endtask

  task automatic setpg(input int pg);
    wr(0, {2'(pg), 6'h21}, 0, "R2 page select");
  endtask

  task automatic sweep_reads(input string tag);
    for (int pg = 0; pg < 4; pg++) begin
      setpg(pg);
      for (int off = 0; off < 16; off++) rd(off, tag);
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected<%0d", wd, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_cmd = 8'h22; m_isr = 8'h80; m_imr = 8'h00; m_cur = 8'h00;
    for (int i = 0; i < 16; i++) p0[i] = 8'h00;
    for (int i = 0; i < 6; i++) sta[i] = 8'h00;
    for (int i = 0; i < 8; i++) mc[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state
    @(negedge clk);
    rd(0, "R1 cmd reset");
    rd(7, "R1 status reset");
    chk(irq_o == 0, "R1 irq reset", irq_o, 0);
    chk(err_o == 0, "R1 err reset", err_o, 0);
    chk(stop_o == 0, "R2 stop reset", stop_o, 0);
    // R1 R7 R8 R9 R10: full map after reset
    sweep_reads("R10 map after reset");

    // write pass over every page and offset (R7 R8 R9 R10)
    for (int pg = 0; pg < 4; pg++) begin
      setpg(pg);
      for (int off = 1; off < 16; off++)
        wr(off, 8'(pg * 37 + off * 11 + 5), (pg >= 2), "R10 write pass");
    end
    // R11: configuration outputs
    chk(ring_start_o == p0[1], "R11 ring start", ring_start_o, p0[1]);
    chk(ring_stop_o  == p0[2], "R11 ring stop", ring_stop_o, p0[2]);
    chk(ring_bound_o == p0[3], "R11 boundary", ring_bound_o, p0[3]);
    chk(tx_page_o    == p0[4], "R11 tx page", tx_page_o, p0[4]);
    chk(tx_count_o   == {p0[6], p0[5]}, "R11 tx count", tx_count_o, {p0[6], p0[5]});
    chk(rdma_addr_o  == {p0[9], p0[8]}, "R11 rdma addr", rdma_addr_o, {p0[9], p0[8]});
    chk(rdma_count_o == {p0[11], p0[10]}, "R11 rdma count", rdma_count_o, {p0[11], p0[10]});
    chk(ring_curr_o  == m_cur, "R11 current page", ring_curr_o, m_cur);
    ldma_addr_i = 16'h5A17;
    sweep_reads("R8 R9 map after writes");

    // R3 R4: mask sweep crossed with each status bit
    setpg(0);
    for (int m = 0; m < 256; m++) begin
      wr(15, 8'(m), 0, "R3 mask write");
      chk(irq_o == 0, "R3 bit7 or idle gives no irq", irq_o, 0);
      for (int b = 0; b < 7; b++) begin
        @(negedge clk);
        isr_set_i = 7'(1 << b);
        @(negedge clk);
        isr_set_i = 0;
        chk(irq_o == m[b], "R3 irq level", irq_o, m[b]);
        m_isr[b] = 1'b1;
        wr(7, 8'(1 << b), 0, "R4 clear write");
        chk(irq_o == 0, "R4 irq after clear", irq_o, 0);
      end
    end
    rd(7, "R4 status empty");

    // R6: set beats clear in the same cycle
    @(negedge clk);
    reg_wr_i = 1; reg_addr_i = 4'd7; reg_wdata_i = 8'h7F; isr_set_i = 7'h05;
    @(negedge clk);
    reg_wr_i = 0; isr_set_i = 0;
    m_isr[6:0] = 7'h05;
    rd(7, "R6 set priority");
    wr(7, 8'h7F, 0, "R4 clear all");
    rd(7, "R4 status after clear");
    // R4: bit 7 untouched by a status write
    wr(7, 8'h80, 0, "R4 bit7 write");
    rd(7, "R4 bit7 kept");

    // R5: stop bit set keeps bit 7, stop bit clear releases it
    wr(0, 8'h01, 0, "R5 stop held");
    chk(stop_o == 1, "R2 stop out", stop_o, 1);
    rd(7, "R5 bit7 kept");
    wr(0, 8'h22, 0, "R5 release");
    rd(7, "R5 bit7 cleared");
    rd(0, "R2 cmd readback");
    chk(stop_o == 0, "R2 stop out low", stop_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule